// File: doc/BRIEF.md
# Oscillator Calibration Period Capture

This block measures how long one reference clock period lasts, counted in cycles of the local counting clock. Software uses the result to trim an on-chip oscillator. Accuracy improves as the counting clock runs faster relative to the reference, so the counter width is a parameter sized for the largest expected ratio.

Four reference sources can be routed to the capture input by a 2-bit remap field:
- a general-purpose pin,
- a real-time-clock line,
- a fast external clock divided by 32,
- the output of an 8-way clock-output multiplexer, which has its own 3-bit select.

The fast clock arrives as a one-cycle tick in the counting domain. A 5-bit counter advances on each tick, and its top bit is the divided reference.

The selected level is synchronized, and its rising edges are detected. At each rising edge a free-running counter is captured, and the period is the difference from the previous capture.

A controller with three states sequences the capture:
- **SETTLE** is entered on reset and on every control write (the *rearm* transition). It ignores edges while the synchronizer still holds samples of the old source.
- **ARM** is entered from SETTLE once the flush count runs out (the *flush done* transition). It waits for the first edge.
- **MEASURE** is entered from ARM on that first edge (the *prime* transition), which only records the counter. In MEASURE every further edge is a *capture* that publishes a period.

Top module: `osc_cal_capture`

## Requirements
- R1: After reset, the result register reads period 0, valid 0 and overflow 0, and the control register reads 0.
- R2: The control register is at address 0, with the remap in bits [1:0] and the clock-output select in bits [4:2], and it reads back what was written. Remap 0 selects the pin, 1 the real-time clock, 2 the divided fast clock and 3 the clock-output multiplexer.
- R3: With remap 3, the reference is line `clkout_in[sel]`, where sel is the 3-bit clock-output select; the other lines have no effect.
- R4: The divided fast clock is bit 4 of a 5-bit counter that advances once per `fast_tick`, so its period is 32 ticks.
- R5: The result register is at address 1, with the period in bits [CNT_W-1:0]. The period equals the number of counting-clock edges between the two edges at which consecutive rising levels are first sampled, modulo 2^CNT_W. It is updated, and valid is set, at the second clock edge after the one that first samples the rising input.
- R6: After reset or a control write, edges captured within the next 3 clock edges are ignored. The first edge after that only primes the previous capture and sets no valid.
- R7: Valid (result bit CNT_W) is set by each period capture. A read of address 1 clears it, except that a capture at the same edge keeps it set.
- R8: Overflow (result bit CNT_W+1) is set when a capture occurs while valid is set and no read happens at that edge. A read of address 1 clears it.
- R9: Only rising edges count: a falling edge of the reference neither captures nor changes the period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_in | input | 1 | Reference source 0: general-purpose pin |
| rtc_in | input | 1 | Reference source 1: real-time-clock line |
| fast_tick | input | 1 | One pulse per fast external clock period, feeding the divider |
| clkout_in | input | 2**MUX_SEL_W | Candidate lines of the clock-output multiplexer |
| bus_addr | input | 1 | Register address: 0 control, 1 result |
| bus_wr | input | 1 | Write strobe (control register) |
| bus_rd | input | 1 | Read strobe; at address 1 it clears valid and overflow |
| bus_wdata | input | 2+MUX_SEL_W | Write data: {clock-output select, remap} |
| bus_rdata | output | CNT_W+2 | Read data of the addressed register |

## Verification
The bench builds the block with CNT_W set to 10 and keeps the default two synchronizer stages. The narrow counter lets a 1500-cycle reference period wrap within a few thousand cycles, so the modulo rule of the period difference is exercised cheaply. The default 5-bit divider and 3-bit clock-output select are kept, so the divide-by-32 path and all eight multiplexer lines are driven in their shipping form. A behavioural model predicts period, valid, overflow and control readback on every cycle, including reads that land on capture edges and writes that land on incoming edges.

// File: rtl/ccap_pkg.sv
package ccap_pkg;

    typedef enum logic [1:0] {
        CAL_SETTLE  = 2'd0,
        CAL_ARM     = 2'd1,
        CAL_MEASURE = 2'd2
    } cal_state_t;

    localparam logic [1:0] SRC_PIN    = 2'd0;
    localparam logic [1:0] SRC_RTC    = 2'd1;
    localparam logic [1:0] SRC_FASTDV = 2'd2;
    localparam logic [1:0] SRC_CLKOUT = 2'd3;

    localparam logic ADDR_CTRL   = 1'b0;
    localparam logic ADDR_RESULT = 1'b1;

endpackage

// File: rtl/ccap_src_sel.sv
module ccap_src_sel #(
    parameter int DIV_BITS  = 5,
    parameter int MUX_SEL_W = 3,
    localparam int MUX_N    = 1 << MUX_SEL_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 pin_in,
    input  logic                 rtc_in,
    input  logic                 fast_tick,
    input  logic [MUX_N-1:0]     clkout_in,
    input  logic [1:0]           remap,
    input  logic [MUX_SEL_W-1:0] out_sel,
    output logic                 ref_level
);
    import ccap_pkg::*;

    logic [DIV_BITS-1:0] div_q;
    logic                div_clk;
    logic                mux_clk;

    // Divider: top bit of a tick counter is the divided reference
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            div_q <= '0;
        else if (fast_tick)
            div_q <= div_q + 1'b1;
    end

    assign div_clk = div_q[DIV_BITS-1];
    assign mux_clk = clkout_in[out_sel];

    always_comb begin
        unique case (remap)
            SRC_PIN:    ref_level = pin_in;
            SRC_RTC:    ref_level = rtc_in;
            SRC_FASTDV: ref_level = div_clk;
            SRC_CLKOUT: ref_level = mux_clk;
        endcase
    end

    // R4
    div_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(div_q) |-> $past(fast_tick));

endmodule

// File: rtl/ccap_edge_sync.sv
module ccap_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    logic [STAGES-1:0] sync_q;
    logic              last_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sync_q[0] <= 1'b0;
                    else        sync_q[0] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sync_q[i] <= 1'b0;
                    else        sync_q[i] <= sync_q[i-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= sync_q[STAGES-1];
    end

    assign rise = sync_q[STAGES-1] & ~last_q;

    // R9
    rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);

endmodule

// File: rtl/ccap_core.sv
module ccap_core #(
    parameter int CNT_W      = 16,
    parameter int SETTLE_CYC = 3,
    localparam int SET_W     = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rise,
    input  logic             rearm,
    input  logic             rd_clr,
    output logic [CNT_W-1:0] period_q,
    output logic             valid_q,
    output logic             ovf_q
);
    import ccap_pkg::*;

    cal_state_t       state_q, state_d;
    logic [SET_W-1:0] settle_q, settle_d;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last_q;
    logic             cap_prime;
    logic             cap_meas;

    assign cap_prime = (state_q == CAL_ARM)     && rise && !rearm;
    assign cap_meas  = (state_q == CAL_MEASURE) && rise && !rearm;

    // Next-state logic
    always_comb begin
        state_d  = state_q;
        settle_d = settle_q;
        if (rearm) begin
            state_d  = CAL_SETTLE;
            settle_d = '0;
        end else begin
            unique case (state_q)
                CAL_SETTLE: begin
                    if (settle_q == SET_W'(SETTLE_CYC - 1))
                        state_d = CAL_ARM;
                    else
                        settle_d = settle_q + 1'b1;
                end
                CAL_ARM: begin
                    if (rise)
                        state_d = CAL_MEASURE;
                end
                CAL_MEASURE: state_d = CAL_MEASURE;
                default:     state_d = CAL_SETTLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= CAL_SETTLE;
            settle_q <= '0;
        end else begin
            state_q  <= state_d;
            settle_q <= settle_d;
        end
    end

    // Counter, capture and flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            last_q   <= '0;
            period_q <= '0;
            valid_q  <= 1'b0;
            ovf_q    <= 1'b0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
            if (cap_prime || cap_meas)
                last_q <= cnt_q;
            if (cap_meas)
                period_q <= cnt_q - last_q;
            if (cap_meas)
                valid_q <= 1'b1;
            else if (rd_clr)
                valid_q <= 1'b0;
            if (cap_meas && valid_q && !rd_clr)
                ovf_q <= 1'b1;
            else if (rd_clr)
                ovf_q <= 1'b0;
        end
    end

    // R8
    ovf_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_q |-> valid_q);

    // R7
    rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && !cap_meas) |=> !valid_q);

    // R6
    prime_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_prime |=> (state_q == CAL_MEASURE) && !$rose(valid_q));

    // R6
    rearm_settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rearm |=> (state_q == CAL_SETTLE));

    // R5
    valid_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid_q) |-> ($past(state_q) == CAL_MEASURE));

endmodule

// File: rtl/osc_cal_capture.sv
module osc_cal_capture #(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2,
    parameter int DIV_BITS    = 5,
    parameter int MUX_SEL_W   = 3,
    localparam int MUX_N      = 1 << MUX_SEL_W,
    localparam int CFG_W      = 2 + MUX_SEL_W,
    localparam int RD_W       = CNT_W + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin_in,
    input  logic             rtc_in,
    input  logic             fast_tick,
    input  logic [MUX_N-1:0] clkout_in,
    input  logic             bus_addr,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [CFG_W-1:0] bus_wdata,
    output logic [RD_W-1:0]  bus_rdata
);
    import ccap_pkg::*;

    logic [1:0]           remap_q;
    logic [MUX_SEL_W-1:0] osel_q;
    logic                 ctrl_wr;
    logic                 res_rd;
    logic                 ref_level;
    logic                 ref_rise;
    logic [CNT_W-1:0]     period;
    logic                 valid;
    logic                 ovf;

    assign ctrl_wr = bus_wr && (bus_addr == ADDR_CTRL);
    assign res_rd  = bus_rd && (bus_addr == ADDR_RESULT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remap_q <= SRC_PIN;
            osel_q  <= '0;
        end else if (ctrl_wr) begin
            remap_q <= bus_wdata[1:0];
            osel_q  <= bus_wdata[CFG_W-1:2];
        end
    end

    ccap_src_sel #(
        .DIV_BITS  (DIV_BITS),
        .MUX_SEL_W (MUX_SEL_W)
    ) u_src (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_in    (pin_in),
        .rtc_in    (rtc_in),
        .fast_tick (fast_tick),
        .clkout_in (clkout_in),
        .remap     (remap_q),
        .out_sel   (osel_q),
        .ref_level (ref_level)
    );

    ccap_edge_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (ref_level),
        .rise  (ref_rise)
    );

    ccap_core #(
        .CNT_W      (CNT_W),
        .SETTLE_CYC (SYNC_STAGES + 1)
    ) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .rise     (ref_rise),
        .rearm    (ctrl_wr),
        .rd_clr   (res_rd),
        .period_q (period),
        .valid_q  (valid),
        .ovf_q    (ovf)
    );

    always_comb begin
        if (bus_addr == ADDR_CTRL)
            bus_rdata = {{(RD_W-CFG_W){1'b0}}, osel_q, remap_q};
        else
            bus_rdata = {ovf, valid, period};
    end

endmodule

// File: tb/sim_osc_cal_capture.sv
module sim_osc_cal_capture;

    localparam int CLK_PERIOD = 10;
    localparam int CW         = 10;
    localparam int NL         = 8;
    localparam int SETTLE     = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pin_in = 1'b0;
    logic          rtc_in = 1'b0;
    logic          fast_tick = 1'b0;
    logic [NL-1:0] clkout_in = '0;
    logic          bus_addr = 1'b1;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [4:0]    bus_wdata = '0;
    logic [CW+1:0] bus_rdata;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    bit chk_on = 0;

    osc_cal_capture #(.CNT_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .rtc_in(rtc_in),
        .fast_tick(fast_tick), .clkout_in(clkout_in), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Stimulus generators: square waves with programmable high/low lengths
    int pin_hi = 0, pin_lo = 0, pin_c = 0;
    int rtc_hi = 0, rtc_lo = 0, rtc_c = 0;
    int ln_hi[NL], ln_lo[NL], ln_c[NL];
    int tick_every = 0, tick_c = 0;

    always @(negedge clk) begin
        if (pin_hi == 0) begin pin_in <= 1'b0; pin_c = 0; end
        else begin
            pin_c++;
            if (pin_in && pin_c >= pin_hi) begin pin_in <= 1'b0; pin_c = 0; end
            else if (!pin_in && pin_c >= pin_lo) begin pin_in <= 1'b1; pin_c = 0; end
        end
        if (rtc_hi == 0) begin rtc_in <= 1'b0; rtc_c = 0; end
        else begin
            rtc_c++;
            if (rtc_in && rtc_c >= rtc_hi) begin rtc_in <= 1'b0; rtc_c = 0; end
            else if (!rtc_in && rtc_c >= rtc_lo) begin rtc_in <= 1'b1; rtc_c = 0; end
        end
        for (int i = 0; i < NL; i++) begin
            ln_c[i]++;
            if (clkout_in[i] && ln_c[i] >= ln_hi[i]) begin clkout_in[i] <= 1'b0; ln_c[i] = 0; end
            else if (!clkout_in[i] && ln_c[i] >= ln_lo[i]) begin clkout_in[i] <= 1'b1; ln_c[i] = 0; end
        end
        tick_c++;
        fast_tick <= (tick_every > 0) && (tick_c % tick_every == 0);
    end

    // Behavioural reference model, compared after every clock edge
    int n, last_w, last_cap, m_period, fdiv, m_src, m_osel;
    bit armed, m_valid, m_ovf;
    bit samp_q[$];

    always @(posedge clk) begin
        bit raw, wr, rd, cap, hit;
        if (!rst_n) begin
            n = 0; last_w = -1; last_cap = 0; m_period = 0; fdiv = 0;
            m_src = 0; m_osel = 0; armed = 0; m_valid = 0; m_ovf = 0;
            samp_q = '{0, 0, 0};
        end else begin
            case (m_src)
                0: raw = pin_in;
                1: raw = rtc_in;
                2: raw = (fdiv >= 16);
                default: raw = clkout_in[m_osel];
            endcase
            wr = bus_wr && !bus_addr;
            rd = bus_rd && bus_addr;
            if (wr) last_w = n;
            hit = samp_q[$-1] && !samp_q[$-2];
            cap = 0;
            if (hit && n > last_w + SETTLE) begin
                if (!armed) begin armed = 1; last_cap = n; end
                else begin
                    cap = 1;
                    m_period = (n - last_cap) & ((1 << CW) - 1);
                    last_cap = n;
                end
            end
            if (cap && m_valid && !rd) m_ovf = 1;
            else if (rd) m_ovf = 0;
            if (cap) m_valid = 1;
            else if (rd) m_valid = 0;
            if (wr) begin
                m_src = int'(bus_wdata[1:0]); m_osel = int'(bus_wdata[4:2]); armed = 0;
            end
            if (fast_tick) fdiv = (fdiv + 1) % 32;
            samp_q.push_back(raw);
            if (samp_q.size() > 8) void'(samp_q.pop_front());
            n++;
            #1;
            if (chk_on) begin
                if (bus_addr) begin
                    chk("R5 period", int'(bus_rdata[CW-1:0]), m_period);
                    chk("R7 valid", int'(bus_rdata[CW]), int'(m_valid));
                    chk("R8 overflow", int'(bus_rdata[CW+1]), int'(m_ovf));
                end else begin
                    chk("R2 control", int'(bus_rdata), m_osel * 4 + m_src);
                end
            end
        end
    end

    task automatic chk(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic wait_n(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic wr_ctrl(input int src, input int osel);
        @(negedge clk);
        bus_addr = 1'b0; bus_wr = 1'b1; bus_wdata = 5'(osel * 4 + src);
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 1'b1;
    endtask

    task automatic rd_res();
        @(negedge clk);
        bus_addr = 1'b1; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        for (int i = 0; i < NL; i++) begin ln_hi[i] = i + 4; ln_lo[i] = i + 4; ln_c[i] = 0; end
        wait_n(4);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1 result after reset", int'(bus_rdata), 0);
        bus_addr = 1'b0; #1;
        chk("R1 control after reset", int'(bus_rdata), 0);
        bus_addr = 1'b1;
        chk_on = 1;

        // R9: asymmetric duty on pin, period 50
        pin_hi = 10; pin_lo = 40;
        wait_n(300);
        chk("R9 pin period rise-to-rise", int'(bus_rdata[CW-1:0]), 50);
        chk("R8 overflow after unread periods", int'(bus_rdata[CW+1]), 1);
        rd_res();

        // R6: fresh reference after a control write, first edge only primes
        pin_hi = 0;
        wr_ctrl(1, 0);
        rd_res();
        rtc_hi = 50; rtc_lo = 50;
        wait_n(70);
        chk("R6 no valid after first edge", int'(bus_rdata[CW]), 0);
        wait_n(100);
        chk("R6 valid after second edge", int'(bus_rdata[CW]), 1);
        chk("R2 rtc source period", int'(bus_rdata[CW-1:0]), 100);

        // R4: divided fast clock
        rd_res();
        wr_ctrl(2, 0);
        tick_every = 1;
        wait_n(200);
        chk("R4 divide-by-32 every tick", int'(bus_rdata[CW-1:0]), 32);
        tick_every = 3;
        wait_n(400);
        chk("R4 divide-by-32 sparse ticks", int'(bus_rdata[CW-1:0]), 96);

        // R3: clock-output multiplexer line selection
        ln_hi[5] = 30; ln_lo[5] = 30;
        wr_ctrl(3, 5);
        wait_n(300);
        chk("R3 clkout line 5", int'(bus_rdata[CW-1:0]), 60);
        wr_ctrl(3, 2);
        wait_n(100);
        chk("R3 clkout line 2", int'(bus_rdata[CW-1:0]), 12);

        // R5: wrap of the period modulo 2^CW
        rd_res();
        wr_ctrl(0, 0);
        pin_hi = 700; pin_lo = 800;
        wait_n(5000);
        chk("R5 wrapped period", int'(bus_rdata[CW-1:0]), 1500 % (1 << CW));

        // R7 R8: frequent reads against a short period, coincidences by model
        pin_hi = 5; pin_lo = 16;
        wait_n(60);
        for (int k = 0; k < 60; k++) begin
            rd_res();
            wait_n(5);
        end

        // R6: back-to-back writes while edges keep arriving
        for (int k = 0; k < 20; k++) begin
            wr_ctrl(k % 4, k % 8);
            wait_n(k % 5);
        end
        wait_n(300);

        done = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

endmodule